// File: doc/BRIEF.md
# Dual Descriptor Ring Pointer Unit

This block keeps the working position of two descriptor rings in memory, one for the transmit engine and one for the receive engine. Each descriptor occupies eight bytes. For each ring, software-supplied configuration gives a start address and a size code. The block presents the byte address of the descriptor each engine should work on next.

An engine pulses its advance input once it has finished with a descriptor. The matching pointer then moves one entry forward. After the last entry it wraps back to the first. An initialization pulse captures new ring configuration and places both pointers at their ring starts. A start pulse puts both pointers back at the captured starts without taking in new configuration. While the suspend input is high, both pointers stay where they are, so the engines pick up at the same descriptors when suspend drops.

Top module: `ring_ptr_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, both captured start addresses become 0, both size codes become 0 (one entry) and both pointers go to their first entry. After that edge both address outputs read 0.
- R2: When `init_i` is high at a clock edge, each ring captures its start address with bits [2:0] forced to 0, captures its size code, and its pointer returns to the first entry. From the next cycle the address output equals the aligned start.
- R3: A size code c gives 2^c entries when c ≤ 9. Any code from 10 to 15 is treated as 9, giving 512 entries.
- R4: An advance accepted at a clock edge raises that ring's address output by 8 after the edge, unless the pointer was on the last entry.
- R5: An advance accepted on the last entry (start + 8·(entries−1)) returns the address output to the ring start. A ring of one entry stays at its start.
- R6: When `start_i` is high at a clock edge and `init_i` is low, both pointers return to the captured starts. The start and size-code inputs are not captured.
- R7: While `suspend_i` is high, advance inputs have no effect and both address outputs stay unchanged. Normal advancing resumes from the held positions once `suspend_i` is low again.
- R8: An advance that coincides with `init_i` or `start_i` is ignored, and the reload takes effect. Reload also takes priority over `suspend_i`.
- R9: The two rings are independent. An advance on one ring never changes the other ring's address output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| init_i | input | 1 | Capture configuration and reload both pointers |
| start_i | input | 1 | Reload both pointers to the captured starts |
| suspend_i | input | 1 | Hold both pointers; advances are ignored |
| tx_base_i | input | ADDR_W (24) | Transmit ring start address |
| tx_size_code_i | input | 4 | Transmit ring size code (log2 of entries) |
| rx_base_i | input | ADDR_W (24) | Receive ring start address |
| rx_size_code_i | input | 4 | Receive ring size code (log2 of entries) |
| tx_adv_i | input | 1 | Transmit engine finished the current descriptor |
| rx_adv_i | input | 1 | Receive engine finished the current descriptor |
| tx_addr_o | output | ADDR_W (24) | Byte address of current transmit descriptor |
| rx_addr_o | output | ADDR_W (24) | Byte address of current receive descriptor |

## Verification
The hardest case to reach is the wrap of the largest ring under a clamped size code. The pointer must walk through all 512 entries before it returns to the start. To get there, the stimulus first initializes with a code of 12 and issues a long run of advances. It then repeats the run with a code of 15, and reaches the last entry each time. Other cases are built by placing a pointer one step before its wrap and then raising suspend, start or init in the same cycle as an advance. This checks the priority order exactly at the boundary.

// File: rtl/ring_ptr_pkg.sv
// Package: shared constants for the descriptor ring pointer unit.
// Assumes a fixed descriptor size of eight bytes and two rings.
package ring_ptr_pkg;
    localparam int DESC_SHIFT = 3;   // log2 of descriptor size in bytes
    localparam int NUM_RINGS  = 2;
    localparam int CODE_W     = 4;

    typedef enum int {
        RING_TX = 0,
        RING_RX = 1
    } ring_id_e;
endpackage

// File: rtl/ring_cfg_reg.sv
// Module: ring_cfg_reg
// Captures the start address and size code of one ring on a load pulse.
// The low descriptor-offset bits of the start address are forced to zero.
// Size codes above MAX_CODE are clamped. The module presents the index of
// the last entry. Assumes ADDR_W > DESC_SHIFT.
module ring_cfg_reg
    import ring_ptr_pkg::*;
#(
    parameter int ADDR_W   = 24,
    parameter int MAX_CODE = 9,
    localparam int IDX_W   = MAX_CODE
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load_i,
    input  logic [ADDR_W-1:0]   base_i,
    input  logic [CODE_W-1:0]   code_i,
    output logic [ADDR_W-1:0]   base_o,
    output logic [IDX_W-1:0]    last_idx_o
);
    logic [ADDR_W-1:0] base_q;
    logic [CODE_W-1:0] code_q;
    logic [CODE_W-1:0] code_clamped;

    // Limit the requested size code to the largest supported ring.
    always_comb begin
        if (int'(code_i) > MAX_CODE) code_clamped = CODE_W'(MAX_CODE);
        else                         code_clamped = code_i;
    end

    // Capture the aligned start address and clamped code on load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            code_q <= '0;
        end else if (load_i) begin
            base_q <= {base_i[ADDR_W-1:DESC_SHIFT], {DESC_SHIFT{1'b0}}};
            code_q <= code_clamped;
        end
    end

    // Last entry index is 2^code - 1, formed as a right-shifted all-ones mask.
    always_comb begin
        last_idx_o = {IDX_W{1'b1}} >> (CODE_W'(MAX_CODE) - code_q);
    end

    assign base_o = base_q;
endmodule

// File: rtl/ring_ptr_walker.sv
// Module: ring_ptr_walker
// Holds the entry index of one ring. A reload returns the index to 0 and
// wins over everything else. A hold blocks advances. An advance steps the
// index and wraps to 0 after the last entry.
module ring_ptr_walker #(
    parameter int IDX_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reload_i,
    input  logic             hold_i,
    input  logic             adv_i,
    input  logic [IDX_W-1:0] last_idx_i,
    output logic [IDX_W-1:0] idx_o
);
    logic [IDX_W-1:0] idx_q;

    // Update the entry index by priority: reload, hold, then advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (reload_i) begin
            idx_q <= '0;
        end else if (adv_i && !hold_i) begin
            if (idx_q == last_idx_i) idx_q <= '0;
            else                     idx_q <= idx_q + 1'b1;
        end
    end

    assign idx_o = idx_q;
endmodule

// File: rtl/ring_addr_gen.sv
// Module: ring_addr_gen
// Combinational byte address of the current descriptor: start plus index
// times the descriptor size. Assumes ADDR_W >= IDX_W + DESC_SHIFT.
// The sum wraps modulo 2^ADDR_W.
module ring_addr_gen
    import ring_ptr_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int IDX_W  = 9,
    localparam int PAD_W = ADDR_W - IDX_W - DESC_SHIFT
) (
    input  logic [ADDR_W-1:0] base_i,
    input  logic [IDX_W-1:0]  idx_i,
    output logic [ADDR_W-1:0] addr_o
);
    logic [ADDR_W-1:0] offset;

    // Scale the index to a byte offset and add it to the ring start.
    always_comb begin
        offset = {{PAD_W{1'b0}}, idx_i, {DESC_SHIFT{1'b0}}};
        addr_o = base_i + offset;
    end
endmodule

// File: rtl/ring_ptr_unit.sv
// Module: ring_ptr_unit (top)
// Working pointers for a transmit ring and a receive ring of 8-byte
// descriptors. init_i captures the configuration and reloads both pointers.
// start_i reloads both pointers only. suspend_i freezes both pointers.
// Each advance input steps its own ring. The ring logic is built by a
// generate loop over NUM_RINGS.
module ring_ptr_unit
    import ring_ptr_pkg::*;
#(
    parameter int ADDR_W   = 24,
    parameter int MAX_CODE = 9
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                init_i,
    input  logic                start_i,
    input  logic                suspend_i,
    input  logic [ADDR_W-1:0]   tx_base_i,
    input  logic [CODE_W-1:0]   tx_size_code_i,
    input  logic [ADDR_W-1:0]   rx_base_i,
    input  logic [CODE_W-1:0]   rx_size_code_i,
    input  logic                tx_adv_i,
    input  logic                rx_adv_i,
    output logic [ADDR_W-1:0]   tx_addr_o,
    output logic [ADDR_W-1:0]   rx_addr_o
);
    localparam int IDX_W = MAX_CODE;

    logic [ADDR_W-1:0] base_in  [NUM_RINGS];
    logic [CODE_W-1:0] code_in  [NUM_RINGS];
    logic              adv_in   [NUM_RINGS];
    logic [ADDR_W-1:0] cfg_base [NUM_RINGS];
    logic [IDX_W-1:0]  last_idx [NUM_RINGS];
    logic [IDX_W-1:0]  cur_idx  [NUM_RINGS];
    logic [ADDR_W-1:0] cur_addr [NUM_RINGS];
    logic              reload;

    // Gather per-ring ports into arrays indexed by ring id.
    always_comb begin
        base_in[RING_TX] = tx_base_i;
        base_in[RING_RX] = rx_base_i;
        code_in[RING_TX] = tx_size_code_i;
        code_in[RING_RX] = rx_size_code_i;
        adv_in[RING_TX]  = tx_adv_i;
        adv_in[RING_RX]  = rx_adv_i;
    end

    assign reload = init_i | start_i;

    for (genvar r = 0; r < NUM_RINGS; r++) begin : g_ring
        ring_cfg_reg #(
            .ADDR_W   (ADDR_W),
            .MAX_CODE (MAX_CODE)
        ) u_cfg (
            .clk        (clk),
            .rst_n      (rst_n),
            .load_i     (init_i),
            .base_i     (base_in[r]),
            .code_i     (code_in[r]),
            .base_o     (cfg_base[r]),
            .last_idx_o (last_idx[r])
        );

        ring_ptr_walker #(
            .IDX_W (IDX_W)
        ) u_walk (
            .clk        (clk),
            .rst_n      (rst_n),
            .reload_i   (reload),
            .hold_i     (suspend_i),
            .adv_i      (adv_in[r]),
            .last_idx_i (last_idx[r]),
            .idx_o      (cur_idx[r])
        );

        ring_addr_gen #(
            .ADDR_W (ADDR_W),
            .IDX_W  (IDX_W)
        ) u_addr (
            .base_i (cfg_base[r]),
            .idx_i  (cur_idx[r]),
            .addr_o (cur_addr[r])
        );
    end

    assign tx_addr_o = cur_addr[RING_TX];
    assign rx_addr_o = cur_addr[RING_RX];
endmodule

// File: rtl/ring_ptr_unit_chk.sv
// Module: ring_ptr_unit_chk
// Temporal checks on the ring pointer unit, attached by bind. It watches
// the ports and the captured start addresses.
module ring_ptr_unit_chk #(
    parameter int ADDR_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              init_i,
    input logic              start_i,
    input logic              suspend_i,
    input logic [ADDR_W-1:0] tx_base_i,
    input logic [ADDR_W-1:0] rx_base_i,
    input logic              tx_adv_i,
    input logic              rx_adv_i,
    input logic [ADDR_W-1:0] tx_addr_o,
    input logic [ADDR_W-1:0] rx_addr_o,
    input logic [ADDR_W-1:0] tx_start_q,
    input logic [ADDR_W-1:0] rx_start_q
);
    localparam logic [ADDR_W-1:0] ALIGN_MASK = ~ADDR_W'(7);
    localparam logic [ADDR_W-1:0] STEP       = ADDR_W'(8);

    // R1
    reset_zero_chk: assert property (@(posedge clk)
        !rst_n |=> (tx_addr_o == '0 && rx_addr_o == '0));

    // R2
    init_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        init_i |=> (tx_addr_o == ($past(tx_base_i) & ALIGN_MASK)
                 && rx_addr_o == ($past(rx_base_i) & ALIGN_MASK)));

    // R6
    start_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !init_i) |=> (tx_addr_o == tx_start_q && rx_addr_o == rx_start_q));

    // R7
    suspend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (suspend_i && !init_i && !start_i) |=> ($stable(tx_addr_o) && $stable(rx_addr_o)));

    // R4
    tx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_adv_i && !suspend_i && !init_i && !start_i)
        |=> (tx_addr_o == $past(tx_addr_o) + STEP || tx_addr_o == tx_start_q));

    // R5
    rx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_adv_i && !suspend_i && !init_i && !start_i)
        |=> (rx_addr_o == $past(rx_addr_o) + STEP || rx_addr_o == rx_start_q));

    // R9
    tx_isolated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_adv_i && !init_i && !start_i) |=> $stable(tx_addr_o));

    // R9
    rx_isolated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_adv_i && !init_i && !start_i) |=> $stable(rx_addr_o));
endmodule

bind ring_ptr_unit ring_ptr_unit_chk #(
    .ADDR_W (ADDR_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .init_i     (init_i),
    .start_i    (start_i),
    .suspend_i  (suspend_i),
    .tx_base_i  (tx_base_i),
    .rx_base_i  (rx_base_i),
    .tx_adv_i   (tx_adv_i),
    .rx_adv_i   (rx_adv_i),
    .tx_addr_o  (tx_addr_o),
    .rx_addr_o  (rx_addr_o),
    .tx_start_q (cfg_base[0]),
    .rx_start_q (cfg_base[1])
);

// File: tb/ring_ptr_unit_bench.sv
// Bench for ring_ptr_unit: a behavioural model built on integers, compared
// with both address outputs on every falling edge.
module ring_ptr_unit_bench;
    localparam int AW = 24;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          init_i = 1'b0, start_i = 1'b0, suspend_i = 1'b0;
    logic [AW-1:0] tx_base_i = '0, rx_base_i = '0;
    logic [3:0]    tx_size_code_i = '0, rx_size_code_i = '0;
    logic          tx_adv_i = 1'b0, rx_adv_i = 1'b0;
    logic [AW-1:0] tx_addr_o, rx_addr_o;

    int n_cmp = 0, n_bad = 0, cyc_cnt = 0;
    bit done = 0;

    // Model state: index 0 = transmit, 1 = receive.
    int m_base [2];
    int m_code [2];
    int m_idx  [2];

    ring_ptr_unit u_ring_ptr_unit (
        .clk(clk), .rst_n(rst_n), .init_i(init_i), .start_i(start_i),
        .suspend_i(suspend_i), .tx_base_i(tx_base_i), .tx_size_code_i(tx_size_code_i),
        .rx_base_i(rx_base_i), .rx_size_code_i(rx_size_code_i),
        .tx_adv_i(tx_adv_i), .rx_adv_i(rx_adv_i),
        .tx_addr_o(tx_addr_o), .rx_addr_o(rx_addr_o)
    );

    always #10 clk = ~clk;   // 50 MHz

    // Watchdog: an overlong run counts as a failure and still reports.
    always @(posedge clk) begin
        cyc_cnt++;
        if (cyc_cnt > 150000 && !done) begin
            n_bad++;
            $display("FAIL watchdog: actual=%0d cycles expected<=150000", cyc_cnt);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    function automatic int clamp_code(input int c);
        return (c > 9) ? 9 : c;
    endfunction

    function automatic logic [AW-1:0] exp_addr(input int r);
        longint a;
        a = longint'(m_base[r]) + longint'(m_idx[r]) * 8;
        return AW'(a);
    endfunction

    // Advance the model by one clock, from the inputs as the edge sees them.
    task automatic model_step();
        bit adv [2];
        adv[0] = tx_adv_i;
        adv[1] = rx_adv_i;
        if (!rst_n) begin
            for (int r = 0; r < 2; r++) begin
                m_base[r] = 0; m_code[r] = 0; m_idx[r] = 0;
            end
        end else if (init_i) begin
            m_base[0] = int'(tx_base_i) & ~7;
            m_base[1] = int'(rx_base_i) & ~7;
            m_code[0] = clamp_code(int'(tx_size_code_i));
            m_code[1] = clamp_code(int'(rx_size_code_i));
            m_idx[0] = 0; m_idx[1] = 0;
        end else if (start_i) begin
            m_idx[0] = 0; m_idx[1] = 0;
        end else if (!suspend_i) begin
            for (int r = 0; r < 2; r++)
                if (adv[r]) m_idx[r] = (m_idx[r] == (1 << m_code[r]) - 1) ? 0 : m_idx[r] + 1;
        end
    endtask

    task automatic compare(input string tag);
        logic [AW-1:0] et, er;
        et = exp_addr(0);
        er = exp_addr(1);
        n_cmp++;
        if (tx_addr_o !== et) begin
            n_bad++;
            $display("FAIL %s tx_addr actual=%h expected=%h", tag, tx_addr_o, et);
        end
        n_cmp++;
        if (rx_addr_o !== er) begin
            n_bad++;
            $display("FAIL %s rx_addr actual=%h expected=%h", tag, rx_addr_o, er);
        end
    endtask

    // One clock: the model follows the rising edge, and the check runs at the falling edge.
    task automatic cyc(input string tag);
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare(tag);
    endtask

    task automatic idle_inputs();
        init_i = 0; start_i = 0; suspend_i = 0; tx_adv_i = 0; rx_adv_i = 0;
    endtask

    task automatic do_init(input logic [AW-1:0] tb, input logic [3:0] tc,
                           input logic [AW-1:0] rb, input logic [3:0] rc, input string tag);
        tx_base_i = tb; tx_size_code_i = tc; rx_base_i = rb; rx_size_code_i = rc;
        init_i = 1;
        cyc(tag);
        idle_inputs();
    endtask

    initial begin
        @(negedge clk);
        // R1: reset state
        rst_n = 0;
        tx_adv_i = 1; rx_adv_i = 1;
        cyc("R1"); cyc("R1");
        idle_inputs();
        rst_n = 1;
        cyc("R1");

        // R2: capture with forced alignment
        do_init(24'h001237, 4'd2, 24'h00A005, 4'd3, "R2");
        cyc("R2");

        // R4 and R5: transmit ring of 4 entries wraps; R9: receive untouched
        tx_adv_i = 1;
        for (int i = 0; i < 6; i++) cyc("R5");
        tx_adv_i = 0;
        cyc("R9");

        // R4: receive ring of 8 entries steps and wraps
        rx_adv_i = 1;
        for (int i = 0; i < 9; i++) cyc("R4");
        rx_adv_i = 0;

        // R7: suspend blocks advances on both rings, then resume
        suspend_i = 1; tx_adv_i = 1; rx_adv_i = 1;
        for (int i = 0; i < 4; i++) cyc("R7");
        suspend_i = 0;
        for (int i = 0; i < 2; i++) cyc("R7");
        tx_adv_i = 0; rx_adv_i = 0;

        // R6: start reloads to captured starts, new start inputs not taken
        tx_base_i = 24'h777770; rx_base_i = 24'h333330;
        tx_size_code_i = 4'd0; rx_size_code_i = 4'd0;
        start_i = 1;
        cyc("R6");
        start_i = 0;
        cyc("R6");

        // R8: advance with start is ignored, also at the wrap point
        tx_adv_i = 1;
        for (int i = 0; i < 3; i++) cyc("R8");
        start_i = 1;
        cyc("R8");
        start_i = 0;
        cyc("R8");
        // R8: reload wins over suspend too
        suspend_i = 1; start_i = 1;
        cyc("R8");
        idle_inputs();

        // R8: advance with init is ignored
        tx_adv_i = 1; rx_adv_i = 1;
        do_init(24'h100000, 4'd12, 24'h200008, 4'd0, "R8");
        cyc("R8");

        // R3: code 12 clamped to 512 entries; R5: single-entry ring stays put
        tx_adv_i = 1; rx_adv_i = 1;
        for (int i = 0; i < 520; i++) cyc("R3");
        idle_inputs();

        // R3: code 15 also clamps to 512
        do_init(24'h040000, 4'd15, 24'h050000, 4'd9, "R3");
        tx_adv_i = 1; rx_adv_i = 1;
        for (int i = 0; i < 514; i++) cyc("R3");
        idle_inputs();

        // R9: mixed pattern on rings of 2 entries
        do_init(24'h000100, 4'd1, 24'h000200, 4'd1, "R9");
        for (int i = 0; i < 12; i++) begin
            tx_adv_i = i[0];
            rx_adv_i = i[1];
            cyc("R9");
        end
        idle_inputs();
        cyc("R9");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule